// File: doc/BRIEF.md
# Enrollment Power-Cycle Sequencer

This block drives the repeated power-up readouts that enrollment of a memory-based unclonable function needs. Each round switches the memory supply off and keeps it off for a discharge interval. Residual charge left in the cells would otherwise pull marginal bits toward the value they held before, so unstable cells would go undetected. The supply then comes back on and the block waits for a settle interval. After that it walks every address of the array in ascending order and hands each word to a downstream statistics accumulator over a valid/ready stream. Each word carries the index of its round.

The discharge interval depends on a two-bit temperature-band input. Cold parts hold charge longest and get the longest wait. A hot part gets the shortest wait. The block reads the band only at the start of each round. Every interval is a whole number of prescaled ticks, and the tick period comes from the clock frequency. A scaling parameter shortens all delays for simulation. A floor parameter stops the off-time from ever becoming near zero. After the programmed number of rounds the block raises a done flag with the supply off. It waits there until a new start pulse arrives.

States and transitions: `ST_IDLE` moves on start to `ST_PWR_OFF_WAIT`. `ST_PWR_OFF_WAIT` moves on timer expiry to `ST_PWR_ON_SETTLE`. `ST_PWR_ON_SETTLE` moves on timer expiry to `ST_READ_ARRAY`. `ST_READ_ARRAY` moves to `ST_NEXT_ROUND` when the last word is accepted. `ST_NEXT_ROUND` moves to `ST_PWR_OFF_WAIT` when more rounds remain, otherwise to `ST_DONE`. `ST_DONE` moves on start to `ST_PWR_OFF_WAIT`.

Top module: `enroll_pwr_seq`

## Requirements
- R1: After reset, pwr_en, word_valid and done are 0 and arr_addr is 0.
- R2: The discharge wait lasts D×K cycles, where K is the prescaler length in cycles and D is the band delay in ticks. The band codes are 2'b00 cold (COLD_MS), 2'b01 room (ROOM_MS) and 2'b10 hot (HOT_MS), and 2'b11 is treated as cold. Between rounds, pwr_en is therefore low for D×K+1 cycles, counted from the cycle after the last accepted word.
- R3: The effective band delay is never below MIN_OFF_MS ticks. A shorter band setting is raised to that floor.
- R4: After pwr_en rises, word_valid stays low for exactly SETTLE_MS×K cycles.
- R5: While word_valid is high, pwr_en is high. Each round presents the addresses 0 to 2^ADDR_W−1 once each in ascending order, and word_data equals mem_rdata at arr_addr.
- R6: While word_valid is high and word_ready is low, word_valid, arr_addr and word_round hold on the next cycle.
- R7: word_round equals the zero-based index of the current round.
- R8: After ROUNDS rounds, done rises with pwr_en and word_valid low. The block stays in that condition until the next start.
- R9: temp_band is sampled only when a round begins. Changing it during the discharge wait does not change the length of that wait.
- R10: A start pulse during enrollment has no effect. The run still ends after exactly ROUNDS rounds.
- R11: A start pulse in the done state clears done and runs a fresh enrollment from round 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted in idle or done |
| temp_band | input | 2 | Temperature band: 00 cold, 01 room, 10 hot, 11 cold |
| pwr_en | output | 1 | Memory supply enable |
| arr_addr | output | ADDR_W | Word address to the array and to the accumulator |
| mem_rdata | input | DATA_W | Word read from the array at arr_addr |
| word_valid | output | 1 | Stream word valid |
| word_ready | input | 1 | Accumulator ready |
| word_data | output | DATA_W | Stream word |
| word_round | output | ROUND_W | Round index of the current word |
| done | output | 1 | Enrollment finished |

## Verification
A wrong timer load or a wrong band mux shows as a wrong count of low or high pwr_en cycles. It appears at the first rising edge of pwr_en after the affected round starts. A faulty address walker or a broken stall path shows at once as a skipped, repeated or advanced arr_addr against the expected ascending sequence. A round counter that is off by one shows as a wrong word_round on the first word of a round. It also shows as a done flag that comes one round early or late. The bench runs a reduced array with short delays through every band code, with the flow both free-running and throttled.

// File: rtl/enroll_pwr_seq_pkg.sv
package enroll_pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR_OFF_WAIT,
        ST_PWR_ON_SETTLE,
        ST_READ_ARRAY,
        ST_NEXT_ROUND,
        ST_DONE
    } seq_state_t;

    localparam logic [1:0] BAND_COLD = 2'b00;
    localparam logic [1:0] BAND_ROOM = 2'b01;
    localparam logic [1:0] BAND_HOT  = 2'b10;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pcyc_tick_timer.sv
module pcyc_tick_timer #(
    parameter int TICK_DIV = 2,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_ticks,
    output logic             expire
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] tick_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            tick_cnt <= '0;
        end else if (load) begin
            pre_cnt  <= PRE_MAX;
            tick_cnt <= load_ticks;
        end else if (tick_cnt != '0) begin
            if (pre_cnt == '0) begin
                pre_cnt  <= PRE_MAX;
                tick_cnt <= tick_cnt - 1'b1;
            end else begin
                pre_cnt <= pre_cnt - 1'b1;
            end
        end
    end

    assign expire = (tick_cnt == CNT_W'(1)) && (pre_cnt == '0);

endmodule

// File: rtl/pcyc_addr_walker.sv
module pcyc_addr_walker #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

    assign last = (addr == {ADDR_W{1'b1}});

endmodule

// File: rtl/pcyc_round_ctr.sv
module pcyc_round_ctr #(
    parameter int ROUNDS  = 1000,
    parameter int ROUND_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               inc,
    output logic [ROUND_W-1:0] round,
    output logic               last_round
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            round <= '0;
        end else if (clear) begin
            round <= '0;
        end else if (inc) begin
            round <= round + 1'b1;
        end
    end

    assign last_round = (round == ROUND_W'(ROUNDS - 1));

endmodule

// File: rtl/enroll_pwr_seq.sv
module enroll_pwr_seq
    import enroll_pwr_seq_pkg::*;
#(
    parameter int CLK_HZ     = 125_000_000,
    parameter int TICK_HZ    = 1000,
    parameter int DELAY_DIV  = 1,
    parameter int COLD_MS    = 21000,
    parameter int ROOM_MS    = 3000,
    parameter int HOT_MS     = 1000,
    parameter int MIN_OFF_MS = 500,
    parameter int SETTLE_MS  = 1,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int ROUNDS     = 1000,
    localparam int ROUND_W   = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         temp_band,
    output logic               pwr_en,
    output logic [ADDR_W-1:0]  arr_addr,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               word_valid,
    input  logic               word_ready,
    output logic [DATA_W-1:0]  word_data,
    output logic [ROUND_W-1:0] word_round,
    output logic               done
);
    localparam int RAW_DIV     = CLK_HZ / TICK_HZ / DELAY_DIV;
    localparam int TICK_DIV    = (RAW_DIV > 0) ? RAW_DIV : 1;
    localparam int EFF_MIN     = int'(imax(MIN_OFF_MS, 1));
    localparam int EFF_COLD    = int'(imax(COLD_MS, EFF_MIN));
    localparam int EFF_ROOM    = int'(imax(ROOM_MS, EFF_MIN));
    localparam int EFF_HOT     = int'(imax(HOT_MS, EFF_MIN));
    localparam int EFF_SETTLE  = int'(imax(SETTLE_MS, 1));
    localparam int MAX_TICKS   = int'(imax(imax(EFF_COLD, EFF_ROOM), imax(EFF_HOT, EFF_SETTLE)));
    localparam int CNT_W       = $clog2(MAX_TICKS + 1);
    localparam int MIN_LOW_CYC = EFF_MIN * TICK_DIV;

    seq_state_t state_q, state_d;

    logic              tmr_load, tmr_expire;
    logic [CNT_W-1:0]  tmr_ticks, off_ticks;
    logic              addr_clear, addr_step, addr_last;
    logic              rnd_clear, rnd_inc, rnd_last;
    logic [ROUND_W-1:0] rnd_idx;

    // Band to discharge delay, floor already applied
    always_comb begin
        unique case (temp_band)
            BAND_ROOM: off_ticks = CNT_W'(EFF_ROOM);
            BAND_HOT:  off_ticks = CNT_W'(EFF_HOT);
            default:   off_ticks = CNT_W'(EFF_COLD);
        endcase
    end

    pcyc_tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_ticks(tmr_ticks), .expire(tmr_expire)
    );

    pcyc_addr_walker #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clear(addr_clear), .step(addr_step),
        .addr(arr_addr), .last(addr_last)
    );

    pcyc_round_ctr #(.ROUNDS(ROUNDS), .ROUND_W(ROUND_W)) u_round (
        .clk(clk), .rst_n(rst_n), .clear(rnd_clear), .inc(rnd_inc),
        .round(rnd_idx), .last_round(rnd_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:          if (start) state_d = ST_PWR_OFF_WAIT;
            ST_PWR_OFF_WAIT:  if (tmr_expire) state_d = ST_PWR_ON_SETTLE;
            ST_PWR_ON_SETTLE: if (tmr_expire) state_d = ST_READ_ARRAY;
            ST_READ_ARRAY:    if (word_ready && addr_last) state_d = ST_NEXT_ROUND;
            ST_NEXT_ROUND:    state_d = rnd_last ? ST_DONE : ST_PWR_OFF_WAIT;
            ST_DONE:          if (start) state_d = ST_PWR_OFF_WAIT;
            default:          state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        pwr_en     = 1'b0;
        word_valid = 1'b0;
        done       = 1'b0;
        tmr_load   = 1'b0;
        tmr_ticks  = off_ticks;
        addr_clear = 1'b0;
        addr_step  = 1'b0;
        rnd_clear  = 1'b0;
        rnd_inc    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_load  = start;
                rnd_clear = start;
            end
            ST_PWR_OFF_WAIT: begin
                tmr_load  = tmr_expire;
                tmr_ticks = CNT_W'(EFF_SETTLE);
            end
            ST_PWR_ON_SETTLE: begin
                pwr_en     = 1'b1;
                addr_clear = tmr_expire;
            end
            ST_READ_ARRAY: begin
                pwr_en     = 1'b1;
                word_valid = 1'b1;
                addr_step  = word_ready;
            end
            ST_NEXT_ROUND: begin
                tmr_load = !rnd_last;
                rnd_inc  = !rnd_last;
            end
            ST_DONE: begin
                done      = 1'b1;
                tmr_load  = start;
                rnd_clear = start;
            end
            default: ;
        endcase
    end

    assign word_data  = mem_rdata;
    assign word_round = rnd_idx;

endmodule

// File: rtl/enroll_pwr_seq_chk.sv
module enroll_pwr_seq_chk #(
    parameter int ADDR_W  = 16,
    parameter int ROUND_W = 10,
    parameter int MIN_LOW = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwr_en,
    input logic [ADDR_W-1:0]  arr_addr,
    input logic               word_valid,
    input logic               word_ready,
    input logic [ROUND_W-1:0] word_round,
    input logic               done
);
    logic [31:0] low_run;
    logic        pwr_q, valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
            pwr_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            pwr_q   <= pwr_en;
            valid_q <= word_valid;
            if (pwr_en)                 low_run <= '0;
            else if (low_run != '1)     low_run <= low_run + 1'b1;
        end
    end

    a_r5_valid_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> pwr_en);

    a_r5_first_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !valid_q) |-> (arr_addr == '0));

    a_r5_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_ready && arr_addr != {ADDR_W{1'b1}})
        |=> (word_valid && arr_addr == ADDR_W'($past(arr_addr) + 1'b1)));

    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready)
        |=> (word_valid && $stable(arr_addr) && $stable(word_round)));

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!pwr_en && !word_valid));

    a_r3_min_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !pwr_q) |-> (low_run >= 32'(MIN_LOW)));

endmodule

bind enroll_pwr_seq enroll_pwr_seq_chk #(
    .ADDR_W(ADDR_W), .ROUND_W(ROUND_W), .MIN_LOW(MIN_LOW_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .arr_addr(arr_addr),
    .word_valid(word_valid), .word_ready(word_ready),
    .word_round(word_round), .done(done)
);

// File: tb/enroll_pwr_seq_tb.sv
module enroll_pwr_seq_tb;
    localparam int K       = 2;
    localparam int COLD    = 7;
    localparam int ROOM    = 4;
    localparam int HOT     = 1;
    localparam int MINOFF  = 2;
    localparam int SETTLE  = 3;
    localparam int AW      = 3;
    localparam int DW      = 16;
    localparam int NR      = 4;
    localparam int NW      = 1 << AW;
    localparam int RW      = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] temp_band = 2'b00;
    logic pwr_en, word_valid, done;
    logic word_ready = 1'b1;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] mem_rdata, word_data;
    logic [RW-1:0] word_round;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 689) ^ 23100);
    endfunction

    assign mem_rdata = pat(int'(arr_addr));

    enroll_pwr_seq #(
        .CLK_HZ(125_000_000), .TICK_HZ(1000), .DELAY_DIV(62500),
        .COLD_MS(COLD), .ROOM_MS(ROOM), .HOT_MS(HOT), .MIN_OFF_MS(MINOFF),
        .SETTLE_MS(SETTLE), .ADDR_W(AW), .DATA_W(DW), .ROUNDS(NR)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .temp_band(temp_band),
        .pwr_en(pwr_en), .arr_addr(arr_addr), .mem_rdata(mem_rdata),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .word_round(word_round), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_off(input logic [1:0] b);
        int d;
        case (b)
            2'b01:   d = ROOM;
            2'b10:   d = HOT;
            default: d = COLD;
        endcase
        return (d < MINOFF) ? MINOFF : d;
    endfunction

    // monitor state
    logic [1:0] band_r [NR];
    bit  mon_on = 0, stall_mode = 0, in_read = 0, prev_pwr = 0, prev_done = 0;
    bit  stall_prev = 0;
    int  cyc = 0, lowcnt = 0, highcnt = 0, exp_addr = 0, cur_round = 0;
    logic [AW-1:0] stall_addr;

    always @(negedge clk) if (mon_on) begin
        cyc++;
        word_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
        if (stall_prev) check(word_valid && arr_addr == stall_addr, "R6", int'(arr_addr), int'(stall_addr));
        stall_prev = 0;
        if (pwr_en && !prev_pwr) begin
            if (cur_round > 0 && cur_round < NR) begin
                // R2 band delay (R3 floor when the band is hot), band changed mid-wait (R9)
                check(lowcnt == eff_off(band_r[cur_round]) * K + 1,
                      (band_r[cur_round] == 2'b10) ? "R3" : "R2/R9",
                      lowcnt, eff_off(band_r[cur_round]) * K + 1);
            end
            highcnt = 0;
            in_read = 0;
            if (cur_round + 1 < NR) temp_band = band_r[cur_round + 1];
        end
        if (!pwr_en) begin
            lowcnt++;
            if (lowcnt == 2 && cur_round > 0 && cur_round < NR) temp_band = ~band_r[cur_round];
        end else begin
            lowcnt = 0;
        end
        if (pwr_en && !word_valid && !in_read) highcnt++;
        if (word_valid) begin
            if (!in_read) check(highcnt == SETTLE * K, "R4", highcnt, SETTLE * K);
            in_read = 1;
            check(pwr_en && arr_addr == AW'(exp_addr), "R5", int'(arr_addr), exp_addr);
            check(word_data == pat(exp_addr), "R5", int'(word_data), int'(pat(exp_addr)));
            check(int'(word_round) == cur_round, "R7", int'(word_round), cur_round);
            if (word_ready) begin
                if (exp_addr == NW - 1) begin
                    exp_addr = 0;
                    cur_round++;
                end else begin
                    exp_addr++;
                end
            end else begin
                stall_prev = 1;
                stall_addr = arr_addr;
            end
        end
        if (done && !prev_done)
            check(cur_round == NR && !pwr_en && !word_valid, "R8", cur_round, NR);
        prev_pwr  = pwr_en;
        prev_done = done;
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        bit ok;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!pwr_en && !word_valid && !done && arr_addr == '0, "R1", int'(pwr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pwr_en && !word_valid && !done, "R1", int'(done), 0);

        // Run A: free flow, bands room, cold, hot(floored), 11(cold)
        band_r[0] = 2'b01; band_r[1] = 2'b00; band_r[2] = 2'b10; band_r[3] = 2'b11;
        temp_band = band_r[0];
        cur_round = 0; exp_addr = 0; stall_mode = 0; prev_pwr = 0; prev_done = 0;
        mon_on = 1;
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start(); // R10: ignored mid-run
        wait_done(ok);
        check(ok, "R8", int'(ok), 1);
        check(cur_round == NR, "R10", cur_round, NR);
        // R8: done held with supply off and no stream
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i % 5 == 0) check(done && !pwr_en && !word_valid, "R8", int'(done), 1);
        end

        // Run B: restart from done with a throttled accumulator
        band_r[0] = 2'b10; band_r[1] = 2'b01; band_r[2] = 2'b10; band_r[3] = 2'b00;
        temp_band = band_r[0];
        cur_round = 0; exp_addr = 0; stall_mode = 1;
        pulse_start();
        check(!done && !pwr_en, "R11", int'(done), 0);
        wait_done(ok);
        check(ok && cur_round == NR, "R11", cur_round, NR);
        mon_on = 0;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule